// File: doc/BRIEF.md
# Shared Reset/Hold Pin Controller

This block owns the logic behind a single active-low device pin that has two roles. After power-up the pin is a hardware reset: pulling it low produces a reset pulse for the rest of the device and floats the serial output. The command decoder can send a one-cycle enable-hold strobe. From then on the same pin is a pause input, and it keeps that role until the next power-on reset.

In pause mode, pulling the pin low while the chip select is active freezes the serial shift logic and floats the serial output. The freeze keeps the current bit position, so the transfer can resume. Entry and exit take effect only during a low phase of the serial clock. An edge of the pin that arrives while SCK is high is held back until SCK returns low. Deselecting the device during a pause ends the pause at once.

The pin, chip select and serial clock are asynchronous. They are brought into the system clock through a synchronizer chain. The reset output is stretched so that it lasts for at least a minimum number of cycles. A mode flag reports which role the pin currently plays.

Top module: `rsthold_pin_ctrl`

## Requirements
- R1: After a power-on reset (por_n low at a clock edge) dev_rst, freeze, so_hiz and hold_mode are all 0.
- R2: In reset role (hold_mode 0), a low level on pin_n drives dev_rst and so_hiz to 1. dev_rst stays 1 for max(L, RST_MIN_CYCLES) cycles, where L is the number of cycles the pin was held low.
- R3: In reset role, a low pin_n never raises freeze, whatever cs_n and sck do.
- R4: In hold role, freeze rises when pin_n is low, cs_n is low and sck is low. Inputs take effect SYNC_STAGES+1 clock edges after they change.
- R5: In hold role, a pin_n fall while sck is high does not freeze. The freeze starts once sck goes low, provided pin_n is still low.
- R6: Freeze ends when pin_n is high while sck is low. A pin_n rise while sck is high leaves freeze at 1 until sck goes low.
- R7: While cs_n is high, freeze is 0. This holds both when cs_n rises during a pause and when pin_n is already low. Freeze returns when cs_n goes low again with pin_n and sck low.
- R8: A one-cycle hold_cmd strobe sets hold_mode to 1. hold_mode stays 1 through further strobes and through any pin activity until the next power-on reset.
- R9: In hold role, a low pin_n never asserts dev_rst.
- R10: While freeze is 1, so_hiz is 1, and toggling sck does not end the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| pin_n | input | 1 | Shared reset/pause pin, asynchronous, active low |
| cs_n | input | 1 | Chip select, asynchronous, active low |
| sck | input | 1 | Serial clock, asynchronous |
| hold_cmd | input | 1 | Enable-hold strobe from the command decoder |
| dev_rst | output | 1 | Stretched reset to the other blocks, active high |
| freeze | output | 1 | Halts the serial shift logic |
| so_hiz | output | 1 | Forces the serial output to high impedance |
| hold_mode | output | 1 | 1 when the pin acts as pause input, 0 when it acts as reset |

## Verification
The hardest states to reach are the deferred transitions. These occur when the pin changes while SCK is high, and when the chip select is dropped with the pin still low. Reaching them requires the pin and SCK to change on the same system clock edge, then SCK to be toggled on its own.

The stimulus table is walked only after the mode strobe has been sent. Each row changes pin, chip select and SCK together and holds them for more than the synchronizer latency. The rows are ordered so that every deferred entry, deferred exit and deselect-abort follows the state it depends on. The reset stretch is measured by counting high cycles of dev_rst for a one-cycle pulse and for a long pulse.

// File: rtl/rhp_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset/hold pin controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rhp_pkg;
    typedef enum logic {
        HQ_RUN    = 1'b0,
        HQ_PAUSED = 1'b1
    } hold_state_t;
endpackage

// File: rtl/rhp_sync.sv
`timescale 1ns/1ps
// Multi-bit synchronizer: each bit passes through STAGES flops.
// Assumes: bits are independent; reset values come from RST_VAL.
module rhp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One register stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rhp_rst_stretch.sv
`timescale 1ns/1ps
// Reset pulse generator: output follows the request and lasts at least MIN_CYCLES.
// Assumes: req is already synchronous to clk.
module rhp_rst_stretch #(
    parameter int MIN_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Start, extend and end the pulse; cnt counts cycles since start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            cnt   <= '0;
        end else if (req) begin
            pulse <= 1'b1;
            if (!pulse) cnt <= '0;
            else if (cnt < LAST) cnt <= cnt + 1'b1;
        end else if (pulse) begin
            if (cnt >= LAST) pulse <= 1'b0;
            else cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rhp_hold_fsm.sv
`timescale 1ns/1ps
// Pause qualifier: enters and leaves the paused state only in an SCK low phase.
// Assumes: all inputs synchronous to clk; req is the active pause request.
module rhp_hold_fsm
    import rhp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cs_n_s,
    input  logic sck_s,
    output logic paused
);
    hold_state_t st, st_nx;

    // Next-state choice for the pause state.
    always_comb begin
        st_nx = st;
        unique case (st)
            HQ_RUN:    if (req && !cs_n_s && !sck_s) st_nx = HQ_PAUSED;
            HQ_PAUSED: if (cs_n_s || (!req && !sck_s)) st_nx = HQ_RUN;
            default:   st_nx = HQ_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= HQ_RUN;
        else st <= st_nx;
    end

    assign paused = (st == HQ_PAUSED);
endmodule

// File: rtl/rsthold_pin_ctrl.sv
`timescale 1ns/1ps
// Shared reset/pause pin controller (top).
// Reset role after power-on; a hold_cmd strobe switches the pin permanently to
// pause role until por_n. Assumes pin_n, cs_n, sck are asynchronous.
module rsthold_pin_ctrl #(
    parameter int SYNC_STAGES    = 2,
    parameter int RST_MIN_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_cmd,
    output logic dev_rst,
    output logic freeze,
    output logic so_hiz,
    output logic hold_mode
);
    localparam int NSYNC = 3;
    localparam logic [NSYNC-1:0] SYNC_IDLE = 3'b110; // pin high, cs high, sck low

    logic [NSYNC-1:0] raw, synced;
    logic pin_s, cs_s, sck_s;

    assign raw = {pin_n, cs_n, sck};

    rhp_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(por_n), .d(raw), .q(synced)
    );
    assign {pin_s, cs_s, sck_s} = synced;

    // Role flag: set by the enable-hold strobe, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) hold_mode <= 1'b0;
        else if (hold_cmd) hold_mode <= 1'b1;
    end

    rhp_rst_stretch #(.MIN_CYCLES(RST_MIN_CYCLES)) u_rst (
        .clk(clk), .rst_n(por_n), .req(!hold_mode && !pin_s), .pulse(dev_rst)
    );

    rhp_hold_fsm u_hold (
        .clk(clk), .rst_n(por_n), .req(hold_mode && !pin_s),
        .cs_n_s(cs_s), .sck_s(sck_s), .paused(freeze)
    );

    assign so_hiz = dev_rst | freeze;
endmodule

// File: rtl/rhp_checker.sv
`timescale 1ns/1ps
// Property checker for rsthold_pin_ctrl, bound to it below.
// Assumes: sees the synchronized inputs of the top module.
module rhp_checker #(
    parameter int MIN_CYC = 16
) (
    input logic clk,
    input logic por_n,
    input logic pin_s,
    input logic cs_s,
    input logic sck_s,
    input logic hold_mode,
    input logic dev_rst,
    input logic freeze,
    input logic so_hiz
);
    logic [15:0] hi_cnt;

    // Counts consecutive cycles with dev_rst high.
    always_ff @(posedge clk) begin
        if (!por_n) hi_cnt <= '0;
        else if (dev_rst) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
        else hi_cnt <= '0;
    end

    a_r2_min_width: assert property (@(posedge clk) disable iff (!por_n)
        $fell(dev_rst) |-> hi_cnt >= 16'(MIN_CYC));
    a_r9_rst_only_reset_role: assert property (@(posedge clk) disable iff (!por_n)
        $rose(dev_rst) |-> $past(!hold_mode && !pin_s));
    a_r4_entry_qualified: assert property (@(posedge clk) disable iff (!por_n)
        $rose(freeze) |-> $past(hold_mode && !pin_s && !cs_s && !sck_s));
    a_r6_exit_qualified: assert property (@(posedge clk) disable iff (!por_n)
        $fell(freeze) |-> $past(cs_s || (pin_s && !sck_s)));
    a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!por_n)
        hold_mode |=> hold_mode);
    a_r10_hiz_in_pause: assert property (@(posedge clk) disable iff (!por_n)
        freeze |-> so_hiz);
    a_r3_no_freeze_reset_role: assert property (@(posedge clk) disable iff (!por_n)
        !hold_mode |-> !freeze);
endmodule

bind rsthold_pin_ctrl rhp_checker u_chk (
    .clk(clk), .por_n(por_n), .pin_s(pin_s), .cs_s(cs_s), .sck_s(sck_s),
    .hold_mode(hold_mode), .dev_rst(dev_rst), .freeze(freeze), .so_hiz(so_hiz)
);

// File: tb/rsthold_pin_ctrl_test.sv
`timescale 1ns/1ps
module rsthold_pin_ctrl_test;
    localparam int RMIN = 16;
    localparam int SETTLE = 4;

    logic clk = 1'b0;
    logic por_n, pin_n, cs_n, sck, hold_cmd;
    logic dev_rst, freeze, so_hiz, hold_mode;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsthold_pin_ctrl #(.SYNC_STAGES(2), .RST_MIN_CYCLES(RMIN)) uut (
        .clk(clk), .por_n(por_n), .pin_n(pin_n), .cs_n(cs_n), .sck(sck),
        .hold_cmd(hold_cmd), .dev_rst(dev_rst), .freeze(freeze),
        .so_hiz(so_hiz), .hold_mode(hold_mode)
    );

    // Row: {req tag[3:0], pin_n, cs_n, sck, expected freeze}; applied in hold role.
    localparam int NV = 13;
    localparam logic [7:0] VEC [NV] = '{
        {4'd4,  1'b1,1'b0,1'b0, 1'b0},
        {4'd5,  1'b0,1'b0,1'b1, 1'b0}, // R5 fall with SCK high: deferred
        {4'd5,  1'b0,1'b0,1'b0, 1'b1},
        {4'd10, 1'b0,1'b0,1'b1, 1'b1}, // R10 SCK ignored in pause
        {4'd6,  1'b1,1'b0,1'b1, 1'b1}, // R6 rise with SCK high: deferred
        {4'd6,  1'b1,1'b0,1'b0, 1'b0},
        {4'd4,  1'b0,1'b0,1'b0, 1'b1}, // R4 direct entry
        {4'd6,  1'b1,1'b0,1'b0, 1'b0},
        {4'd4,  1'b0,1'b0,1'b0, 1'b1},
        {4'd7,  1'b0,1'b1,1'b0, 1'b0}, // R7 deselect ends pause
        {4'd7,  1'b0,1'b1,1'b0, 1'b0},
        {4'd7,  1'b0,1'b0,1'b0, 1'b1},
        {4'd7,  1'b1,1'b1,1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse pin_n low for len cycles and count dev_rst high samples.
    task automatic rst_pulse(input int len, output int hi);
        hi = 0;
        pin_n = 1'b0;
        for (int i = 1; i <= len + RMIN + 12; i++) begin
            @(negedge clk);
            if (i == len) pin_n = 1'b1;
            if (dev_rst) hi++;
            if (i == 3 && len > 3) begin
                check("R2 so_hiz during reset", so_hiz, 1'b1);
                check("R3 no freeze in reset role", freeze, 1'b0);
            end
        end
    endtask

    initial begin
        #(2.5 * 2 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        por_n = 1'b0; pin_n = 1'b1; cs_n = 1'b1; sck = 1'b0; hold_cmd = 1'b0;
        wait_n(5);
        por_n = 1'b1;
        wait_n(1);
        // R1 reset state
        check("R1 dev_rst", dev_rst, 1'b0);
        check("R1 freeze", freeze, 1'b0);
        check("R1 so_hiz", so_hiz, 1'b0);
        check("R1 hold_mode", hold_mode, 1'b0);

        // R2 stretch of a short and a long pulse; R3 with cs and sck low
        cs_n = 1'b0;
        rst_pulse(1, hi);
        n_chk++; if (hi != RMIN) begin n_bad++; $display("FAIL R2 short pulse width: actual %0d expected %0d", hi, RMIN); end
        rst_pulse(40, hi);
        n_chk++; if (hi != 40) begin n_bad++; $display("FAIL R2 long pulse width: actual %0d expected %0d", hi, 40); end
        check("R8 mode unchanged by reset", hold_mode, 1'b0);
        cs_n = 1'b1;

        // R8 switch role
        hold_cmd = 1'b1; wait_n(1); hold_cmd = 1'b0; wait_n(1);
        check("R8 hold_mode set", hold_mode, 1'b1);

        // R9 pin low in hold role with CE high: no reset, no freeze
        pin_n = 1'b0; wait_n(30);
        check("R9 no dev_rst", dev_rst, 1'b0);
        check("R7 no freeze while deselected", freeze, 1'b0);
        pin_n = 1'b1; wait_n(SETTLE);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [3:0] rq;
            {rq, pin_n, cs_n, sck} = VEC[v][7:1];
            wait_n(SETTLE);
            check($sformatf("R%0d row %0d freeze", rq, v), freeze, VEC[v][0]);
            check($sformatf("R10 row %0d so_hiz", v), so_hiz, VEC[v][0]);
            check($sformatf("R9 row %0d dev_rst", v), dev_rst, 1'b0);
        end

        // R10 SCK toggling while paused does not end pause
        pin_n = 1'b0; cs_n = 1'b0; sck = 1'b0; wait_n(SETTLE);
        for (int k = 0; k < 6; k++) begin sck = ~sck; wait_n(SETTLE); end
        check("R10 pause kept under SCK toggles", freeze, 1'b1);
        pin_n = 1'b1; cs_n = 1'b1; wait_n(SETTLE);

        // R8 repeated strobe, then power-on reset clears the role
        hold_cmd = 1'b1; wait_n(1); hold_cmd = 1'b0; wait_n(1);
        check("R8 repeated strobe keeps mode", hold_mode, 1'b1);
        por_n = 1'b0; wait_n(2); por_n = 1'b1; wait_n(1);
        check("R8 por clears mode", hold_mode, 1'b0);
        pin_n = 1'b0; wait_n(SETTLE);
        check("R2 reset role restored", dev_rst, 1'b1);
        pin_n = 1'b1; wait_n(RMIN + 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule